// File: doc/BRIEF.md
# Lane Execution Mask Nesting Stack

This block tracks which lanes of a 64-lane SIMD datapath are allowed to execute while a program runs through nested two-way branches. A sequencer issues one structured command per clock: open a region with a per-lane condition vector, switch to the opposite arm of the region, or close the region. Each open saves the mask in force at that moment into a slot of a small hardware stack. The new mask keeps only the lanes that were already active and whose condition bit is set.

Switching arms flips the live mask and then masks it with the saved value. Lanes that were idle outside the region therefore stay idle on both arms. Closing a region brings the saved mask back. The block also drives a registered flag that is high whenever no lane is active, so the sequencer can jump over the body of an empty arm. Stack misuse is reported on two single-cycle error pulses: an open with every slot taken, or a switch or close with nothing saved. A load port can reset the mask to any value at any time and clear the stack.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset, exec_mask is all ones, exec_none is 0, both error flags are 0 and the stack holds no entries.
- R2: A command is taken when cmd_valid is 1. Opcode 2'b01 (open) saves exec_mask on the stack and loads exec_mask with cond & exec_mask. The new value shows on the outputs one clock after the command.
- R3: Opcode 2'b10 (switch arm) loads exec_mask with ~exec_mask & (newest saved mask) and leaves the stack unchanged, so a later close still restores that saved mask.
- R4: Opcode 2'b11 (close) loads exec_mask with the newest saved mask and removes that entry. Nested regions restore their masks in last-in, first-out order.
- R5: exec_none is 1 exactly in the cycles where exec_mask is all zero, and changes in the same cycle as exec_mask.
- R6: The stack holds 8 entries. An open while 8 entries are held raises err_overflow for one cycle and changes neither exec_mask nor the stack.
- R7: A switch or close while the stack is empty raises err_underflow for one cycle and leaves exec_mask unchanged.
- R8: When init_load is 1, exec_mask is loaded with init_mask and the stack is emptied on the next clock. Any command in that cycle is ignored and raises no error flag.
- R9: With cmd_valid at 0, or with opcode 2'b00, exec_mask and the stack do not change, and both error flags are 0 in the following cycle.

The controller has three states: ST_EMPTY (no saved masks), ST_NESTED (1 to 7 saved) and ST_FULL (8 saved). Transition T_OPEN (a push) moves from ST_EMPTY or ST_NESTED one level deeper, ending in ST_FULL on the eighth push. Transition T_CLOSE (a pop) moves from ST_NESTED or ST_FULL one level up, ending in ST_EMPTY on the last pop. Transition T_CLEAR (init_load) moves from any state to ST_EMPTY. Reset enters ST_EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_load | input | 1 | Load init_mask into the mask and clear the stack |
| init_mask | input | 64 | Value loaded by init_load |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 none, 01 open, 10 switch arm, 11 close |
| cond | input | 64 | Per-lane condition bits used by open |
| exec_mask | output | 64 | Current active-lane mask |
| exec_none | output | 1 | High when no lane is active |
| err_overflow | output | 1 | One-cycle pulse: open refused because the stack is full |
| err_underflow | output | 1 | One-cycle pulse: switch or close refused because the stack is empty |

## Verification
The assertions check these rules on every cycle:
- The zero flag always agrees with the mask.
- An open never turns a lane on.
- A switch that succeeds never keeps a lane that was active before it.
- Idle cycles and refused commands leave the mask unchanged.
- A load always lands the loaded value.
- The two error flags are never high together.

Properties cannot see the exact value restored by a switch or a close, the last-in, first-out order across eight nested levels, or the point at which the stack becomes full or empty. Only the bench scenarios can show those, because they compare against a reference model that keeps its own stack.

// File: rtl/lane_mask_stack_pkg.sv
package lane_mask_stack_pkg;

    typedef enum logic [1:0] {
        OP_NOP   = 2'b00,
        OP_IF    = 2'b01,
        OP_ELSE  = 2'b10,
        OP_ENDIF = 2'b11
    } mask_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'b00,
        ST_NESTED = 2'b01,
        ST_FULL   = 2'b10
    } depth_state_e;

endpackage

// File: rtl/mask_ctrl_fsm.sv
module mask_ctrl_fsm
    import lane_mask_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_load,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    output logic             do_push,
    output logic             do_pop,
    output logic             do_else,
    output logic             ovf_now,
    output logic             unf_now,
    output logic [PTR_W-1:0] depth
);

    depth_state_e state, state_nxt;
    logic [PTR_W-1:0] depth_nxt;
    mask_op_e op;

    assign op = mask_op_e'(cmd_op);

    // state register and depth counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            depth <= '0;
        end else begin
            state <= state_nxt;
            depth <= depth_nxt;
        end
    end

    // transitions: T_OPEN, T_CLOSE, T_CLEAR
    always_comb begin
        depth_nxt = depth;
        if (init_load)
            depth_nxt = '0;
        else if (do_push)
            depth_nxt = depth + PTR_W'(1);
        else if (do_pop)
            depth_nxt = depth - PTR_W'(1);

        if (depth_nxt == '0)
            state_nxt = ST_EMPTY;
        else if (depth_nxt == PTR_W'(DEPTH))
            state_nxt = ST_FULL;
        else
            state_nxt = ST_NESTED;
    end

    // outputs per state
    always_comb begin
        do_push = 1'b0;
        do_pop  = 1'b0;
        do_else = 1'b0;
        ovf_now = 1'b0;
        unf_now = 1'b0;
        if (cmd_valid && !init_load) begin
            unique case (state)
                ST_EMPTY: begin
                    if (op == OP_IF)
                        do_push = 1'b1;
                    else if (op == OP_ELSE || op == OP_ENDIF)
                        unf_now = 1'b1;
                end
                ST_NESTED: begin
                    if (op == OP_IF)
                        do_push = 1'b1;
                    else if (op == OP_ELSE)
                        do_else = 1'b1;
                    else if (op == OP_ENDIF)
                        do_pop = 1'b1;
                end
                ST_FULL: begin
                    if (op == OP_IF)
                        ovf_now = 1'b1;
                    else if (op == OP_ELSE)
                        do_else = 1'b1;
                    else if (op == OP_ENDIF)
                        do_pop = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mask_save_stack.sv
module mask_save_stack #(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PTR_W-1:0] depth,
    input  logic [LANES-1:0] wr_data,
    output logic [LANES-1:0] top
);

    logic [LANES-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [LANES-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (push && depth == PTR_W'(i))
                q <= wr_data;
        end
        assign slot_q[i] = q;
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (depth == PTR_W'(i + 1))
                top = slot_q[i];
    end

endmodule

// File: rtl/mask_next_calc.sv
module mask_next_calc #(
    parameter int LANES = 64
) (
    input  logic             init_load,
    input  logic [LANES-1:0] init_mask,
    input  logic             do_push,
    input  logic             do_else,
    input  logic             do_pop,
    input  logic [LANES-1:0] cur,
    input  logic [LANES-1:0] cond,
    input  logic [LANES-1:0] top,
    output logic [LANES-1:0] nxt
);

    always_comb begin
        if (init_load)
            nxt = init_mask;
        else if (do_push)
            nxt = cond & cur;
        else if (do_else)
            nxt = ~cur & top;
        else if (do_pop)
            nxt = top;
        else
            nxt = cur;
    end

endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack
    import lane_mask_stack_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_load,
    input  logic [LANES-1:0] init_mask,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] exec_mask,
    output logic             exec_none,
    output logic             err_overflow,
    output logic             err_underflow
);

    logic             do_push, do_pop, do_else, ovf_now, unf_now;
    logic [PTR_W-1:0] depth;
    logic [LANES-1:0] top, exec_nxt;

    mask_ctrl_fsm #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_load (init_load),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .do_else   (do_else),
        .ovf_now   (ovf_now),
        .unf_now   (unf_now),
        .depth     (depth)
    );

    mask_save_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (do_push),
        .depth   (depth),
        .wr_data (exec_mask),
        .top     (top)
    );

    mask_next_calc #(.LANES(LANES)) u_calc (
        .init_load (init_load),
        .init_mask (init_mask),
        .do_push   (do_push),
        .do_else   (do_else),
        .do_pop    (do_pop),
        .cur       (exec_mask),
        .cond      (cond),
        .top       (top),
        .nxt       (exec_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_mask     <= '1;
            exec_none     <= 1'b0;
            err_overflow  <= 1'b0;
            err_underflow <= 1'b0;
        end else begin
            exec_mask     <= exec_nxt;
            exec_none     <= (exec_nxt == '0);
            err_overflow  <= ovf_now;
            err_underflow <= unf_now;
        end
    end

endmodule

// File: rtl/lane_mask_stack_chk.sv
module lane_mask_stack_chk
    import lane_mask_stack_pkg::*;
#(
    parameter int LANES = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_load,
    input logic [LANES-1:0] init_mask,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [LANES-1:0] exec_mask,
    input logic             exec_none,
    input logic             err_overflow,
    input logic             err_underflow
);

    // R5
    exec_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_none == (exec_mask == '0));

    // R2
    if_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !init_load && cmd_op == OP_IF)
        |=> ((exec_mask & ~$past(exec_mask)) == '0));

    // R3
    else_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !init_load && cmd_op == OP_ELSE)
        |=> (err_underflow || ((exec_mask & $past(exec_mask)) == '0)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> exec_mask == $past(exec_mask));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> exec_mask == $past(exec_mask));

    // R8
    init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> (exec_mask == $past(init_mask) && !err_overflow && !err_underflow));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !init_load) |=> ($stable(exec_mask) && !err_overflow && !err_underflow));

    // R6
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_overflow && err_underflow));

endmodule

bind lane_mask_stack lane_mask_stack_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .init_load     (init_load),
    .init_mask     (init_mask),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .exec_mask     (exec_mask),
    .exec_none     (exec_none),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
);

// File: tb/sim_lane_mask_stack.sv
`timescale 1ns/1ps
module sim_lane_mask_stack;

    localparam int LANES = 64;
    localparam int DEPTH = 8;

    typedef struct {
        logic [LANES-1:0] exec;
        logic             none;
        logic             ovf;
        logic             unf;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_load = 1'b0;
    logic [LANES-1:0] init_mask = '0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic [LANES-1:0] cond = '0;
    logic [LANES-1:0] exec_mask;
    logic             exec_none, err_overflow, err_underflow;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    exp_t             sb_q[$];
    logic [LANES-1:0] m_stk[$];
    logic [LANES-1:0] m_exec;

    always #2.5 clk = ~clk;

    lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_mask(init_mask),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cond(cond),
        .exec_mask(exec_mask), .exec_none(exec_none),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic v, input logic [1:0] op, input logic [LANES-1:0] c,
                        input logic ld, input logic [LANES-1:0] ldv, input string tag);
        exp_t e;
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cond = c; init_load = ld; init_mask = ldv;
        e.ovf = 1'b0; e.unf = 1'b0;
        if (ld) begin
            m_exec = ldv;
            m_stk.delete();
        end else if (v) begin
            case (op)
                2'b01: if (m_stk.size() == DEPTH) e.ovf = 1'b1;
                       else begin m_stk.push_back(m_exec); m_exec = m_exec & c; end
                2'b10: if (m_stk.size() == 0) e.unf = 1'b1;
                       else m_exec = ~m_exec & m_stk[$];
                2'b11: if (m_stk.size() == 0) e.unf = 1'b1;
                       else m_exec = m_stk.pop_back();
                default: ;
            endcase
        end
        e.exec = m_exec;
        e.none = (m_exec == '0);
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compares after each active edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (exec_mask !== e.exec || exec_none !== e.none ||
                err_overflow !== e.ovf || err_underflow !== e.unf) begin
                fails++;
                $display("FAIL %s: got exec=%h none=%b ovf=%b unf=%b, expected exec=%h none=%b ovf=%b unf=%b",
                         e.tag, exec_mask, exec_none, err_overflow, err_underflow,
                         e.exec, e.none, e.ovf, e.unf);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [LANES-1:0] PA = 64'hF0F0_A5A5_3C3C_FFFF;
    localparam logic [LANES-1:0] PB = 64'h0FF0_00FF_1234_8001;

    initial begin
        m_exec = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 2'b00, '0, 0, '0, "R1 reset");
        step(1, 2'b11, '0, 0, '0, "R1 empty stack after reset / R7 close underflow");
        step(1, 2'b10, '0, 0, '0, "R7 switch underflow");
        // R2, R3, R4 single region
        step(1, 2'b01, PA, 0, '0, "R2 open");
        step(1, 2'b10, '1, 0, '0, "R3 switch arm");
        step(1, 2'b11, '0, 0, '0, "R4 close");
        // R4 nesting, R5 zero flag
        step(1, 2'b01, PA, 0, '0, "R2 open level1");
        step(1, 2'b01, PB, 0, '0, "R2 open level2");
        step(1, 2'b01, ~PB, 0, '0, "R5 open to all zero");
        step(1, 2'b10, '0, 0, '0, "R3 switch from zero");
        step(1, 2'b11, '0, 0, '0, "R4 close level3");
        step(1, 2'b11, '0, 0, '0, "R4 close level2");
        step(1, 2'b10, '0, 0, '0, "R3 switch level1 keeps entry");
        step(1, 2'b11, '0, 0, '0, "R4 close level1");
        // R9 idle and nop
        step(0, 2'b01, '0, 0, '0, "R9 invalid open ignored");
        step(1, 2'b00, '0, 0, '0, "R9 nop opcode");
        step(1, 2'b11, '0, 0, '0, "R9 stack unchanged by idle");
        // R6 fill to 8 then overflow
        for (int i = 0; i < DEPTH; i++)
            step(1, 2'b01, ~(64'h1 << (i * 5)), 0, '0, "R6 fill");
        step(1, 2'b01, '0, 0, '0, "R6 overflow");
        step(0, 2'b00, '0, 0, '0, "R6 overflow pulse ends");
        step(1, 2'b10, '0, 0, '0, "R3 switch at full");
        step(1, 2'b10, '0, 0, '0, "R3 switch back at full");
        for (int i = 0; i < DEPTH; i++)
            step(1, 2'b11, '0, 0, '0, "R4 unwind");
        step(1, 2'b11, '0, 0, '0, "R7 underflow after unwind");
        // R8 load overrides command and clears stack
        step(1, 2'b01, PB, 0, '0, "R2 open before load");
        step(1, 2'b01, PA, 1, 64'h0000_FFFF_0000_0001, "R8 load overrides open");
        step(1, 2'b11, '0, 0, '0, "R8 stack cleared");
        step(1, 2'b01, '0, 1, '0, "R8 load zero / R5");
        step(0, 2'b00, '0, 0, '0, "R5 zero held");
        @(negedge clk);
        cmd_valid = 0; init_load = 0;
        repeat (2) @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule